// File: doc/BRIEF.md
# Store undo log queue

This block pairs a word-addressed memory with an undo log for speculative stores. After a checkpoint is opened, every store still goes straight into memory. The first store to each address also records that address and the word it is about to replace in a small log. Later stores to an address that is already logged add nothing, so each entry holds the value the word had when the checkpoint was opened.

A commit empties the log in one cycle and keeps all the speculative writes. A rollback puts memory back as it was at the checkpoint. It does this by writing the logged words back to their addresses, one entry per cycle. While it does so it raises a busy flag and holds off new stores. It also sends a one-cycle flush request so that caches above the memory can drop any state they hold. If the log is full and a store arrives for an address the log does not yet hold, the store is held and an overflow flag stays high until the checkpoint is resolved.

Top module: `undo_log_queue`

## Requirements
- R1: A `ckpt_take` pulse while neither speculative nor busy sets `spec_active` from the next cycle. A take while already speculative or while busy has no effect.
- R2: While speculative, an accepted store to an address not in the log creates one entry holding that address and the old memory word. The new data reaches memory at the same clock edge.
- R3: While speculative, a store to an address already in the log creates no entry. A later rollback restores the word that address held when the checkpoint was opened.
- R4: When no checkpoint is active, accepted stores write memory and leave the log empty. A later checkpoint and rollback do not undo them.
- R5: A commit while speculative empties the whole log at the next edge, keeps the memory contents and clears `spec_active`. A store accepted in the same cycle as the commit is not logged.
- R6: A rollback while speculative makes `busy` high from the next cycle. It stays high for N cycles when N entries are logged, and for 1 cycle when the log is empty. `st_ready` is low in the rollback cycle and in every busy cycle. When `busy` falls, every logged word is back in memory.
- R7: An accepted rollback raises `flush_req` for exactly one cycle, in the first busy cycle. No other event raises it.
- R8: While speculative with all log entries in use, a store to an address not in the log is refused (`st_ready` low, memory unchanged), and `overflow` rises at the next edge. `overflow` stays high until a commit or rollback clears it. A store to an address that is already logged is still accepted while the log is full.
- R9: When several command pulses come in the same cycle, only the strongest takes effect: rollback first, then commit, then take. All commands are ignored while busy.
- R10: After reset, `spec_active`, `busy`, `overflow` and `flush_req` are low, the log is empty and `st_ready` is high.
- R11: `rd_data` shows the memory word at `rd_addr` combinationally, with speculative stores included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store accepted this cycle when high together with st_valid |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Memory word at rd_addr |
| ckpt_take | input | 1 | Open a checkpoint |
| ckpt_commit | input | 1 | Keep speculative stores and empty the log |
| ckpt_rollback | input | 1 | Undo speculative stores by replaying the log |
| spec_active | output | 1 | A checkpoint is open |
| busy | output | 1 | Rollback replay in progress |
| overflow | output | 1 | A new address was refused because the log is full |
| flush_req | output | 1 | One-cycle request for upper levels to discard contents |

## Verification
A wrong entry in the log stays hidden until a rollback. It then shows up as a wrong `rd_data` word, and the first read after `busy` falls exposes it. A missing or extra entry shows up sooner, as a wrong busy length or as a premature `st_ready` drop and `overflow` rise on the store that should have fitted. The bench therefore compares the ready, busy, flag and read outputs against a behavioural model on every cycle. It also sweeps the whole memory after each commit and rollback.

// File: rtl/ulq_pkg.sv
package ulq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SPEC   = 2'd1,
    ST_REPLAY = 2'd2
  } ulq_state_e;

endpackage

// File: rtl/ulq_mem.sv
module ulq_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] words_q [WORDS];

  // storage array: no reset, write enabled per access
  always_ff @(posedge clk) begin
    if (we) begin
      words_q[waddr] <= wdata;
    end
  end

  assign rdata_a = words_q[raddr_a];
  assign rdata_b = words_q[raddr_b];

endmodule

// File: rtl/ulq_log.sv
module ulq_log #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              clear,
  input  logic              pop,
  input  logic [ADDR_W-1:0] match_addr,
  output logic              hit,
  output logic [DEPTH-1:0]  valid_vec,
  output logic [ADDR_W-1:0] pop_addr,
  output logic [DATA_W-1:0] pop_data
);

  logic [DEPTH-1:0]  valid_q, valid_d;
  logic [DEPTH-1:0]  match;
  logic [DEPTH-1:0]  free_sel;
  logic [DEPTH-1:0]  pop_sel;
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];

  // lowest free slot and lowest occupied slot, one-hot
  assign free_sel = ~valid_q & (valid_q + DEPTH'(1));
  assign pop_sel  = valid_q & (~valid_q + DEPTH'(1));

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    // every slot compares against the incoming address in parallel
    assign match[g] = valid_q[g] && (slot_addr[g] == match_addr);

    always_ff @(posedge clk) begin
      if (push && free_sel[g]) begin
        slot_addr[g] <= push_addr;
        slot_data[g] <= push_data;
      end
    end
  end

  assign hit = |match;

  always_comb begin
    pop_addr = '0;
    pop_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_sel[i]) begin
        pop_addr = pop_addr | slot_addr[i];
        pop_data = pop_data | slot_data[i];
      end
    end
  end

  always_comb begin
    if (clear) begin
      valid_d = '0;
    end else begin
      valid_d = valid_q;
      if (push) valid_d = valid_d | free_sel;
      if (pop)  valid_d = valid_d & ~pop_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (clear || push || pop) begin
      valid_q <= valid_d;
    end
  end

  assign valid_vec = valid_q;

endmodule

// File: rtl/ulq_ctrl.sv
module ulq_ctrl
  import ulq_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic take,
  input  logic commit,
  input  logic rollback,
  input  logic st_valid,
  input  logic hit,
  input  logic full,
  input  logic empty,
  input  logic last,
  output logic spec,
  output logic busy,
  output logic flush_req,
  output logic overflow,
  output logic st_ready,
  output logic push,
  output logic clear,
  output logic pop
);

  ulq_state_e state_q, state_d;
  logic       ovf_q, ovf_d;
  logic       flush_q, flush_d;

  assign spec = (state_q == ST_SPEC);
  assign busy = (state_q == ST_REPLAY);

  assign st_ready = !busy && !(spec && (rollback || (full && !hit)));
  assign push     = spec && st_valid && st_ready && !hit && !commit;
  assign clear    = spec && commit && !rollback;
  assign pop      = busy && !empty;

  always_comb begin
    state_d = state_q;
    ovf_d   = ovf_q;
    flush_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (take && !commit && !rollback) state_d = ST_SPEC;
      end
      ST_SPEC: begin
        if (rollback) begin
          state_d = ST_REPLAY;
          ovf_d   = 1'b0;
          flush_d = 1'b1;
        end else if (commit) begin
          state_d = ST_IDLE;
          ovf_d   = 1'b0;
        end else if (st_valid && full && !hit) begin
          ovf_d   = 1'b1;
        end
      end
      ST_REPLAY: begin
        if (empty || last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ovf_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ovf_q   <= ovf_d;
      flush_q <= flush_d;
    end
  end

  assign overflow  = ovf_q;
  assign flush_req = flush_q;

endmodule

// File: rtl/undo_log_queue.sv
module undo_log_queue #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16,
  parameter int LOG_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ckpt_take,
  input  logic              ckpt_commit,
  input  logic              ckpt_rollback,
  output logic              spec_active,
  output logic              busy,
  output logic              overflow,
  output logic              flush_req
);

  // reset: asserted asynchronously, released after two clean edges
  logic [1:0] rst_pipe_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  logic [LOG_DEPTH-1:0] log_valid;
  logic                 log_hit, log_full, log_empty, log_last;
  logic                 do_push, do_clear, do_pop;
  logic [ADDR_W-1:0]    pop_addr;
  logic [DATA_W-1:0]    pop_data;
  logic [DATA_W-1:0]    old_word;
  logic                 store_acc;
  logic                 mem_we;
  logic [ADDR_W-1:0]    mem_waddr;
  logic [DATA_W-1:0]    mem_wdata;

  assign log_full  = &log_valid;
  assign log_empty = ~|log_valid;
  assign log_last  = !log_empty && ((log_valid & (log_valid - LOG_DEPTH'(1))) == '0);

  ulq_ctrl u_ctrl (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .take      (ckpt_take),
    .commit    (ckpt_commit),
    .rollback  (ckpt_rollback),
    .st_valid  (st_valid),
    .hit       (log_hit),
    .full      (log_full),
    .empty     (log_empty),
    .last      (log_last),
    .spec      (spec_active),
    .busy      (busy),
    .flush_req (flush_req),
    .overflow  (overflow),
    .st_ready  (st_ready),
    .push      (do_push),
    .clear     (do_clear),
    .pop       (do_pop)
  );

  ulq_log #(
    .DEPTH  (LOG_DEPTH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_log (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .push       (do_push),
    .push_addr  (st_addr),
    .push_data  (old_word),
    .clear      (do_clear),
    .pop        (do_pop),
    .match_addr (st_addr),
    .hit        (log_hit),
    .valid_vec  (log_valid),
    .pop_addr   (pop_addr),
    .pop_data   (pop_data)
  );

  // replay owns the write port while busy; stores are stalled then
  assign store_acc = st_valid && st_ready;
  assign mem_we    = do_pop || store_acc;
  assign mem_waddr = do_pop ? pop_addr : st_addr;
  assign mem_wdata = do_pop ? pop_data : st_data;

  ulq_mem #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr_a (rd_addr),
    .rdata_a (rd_data),
    .raddr_b (st_addr),
    .rdata_b (old_word)
  );

endmodule

// File: rtl/ulq_checker.sv
module ulq_checker #(
  parameter int LOG_DEPTH = 8
) (
  input logic                 clk,
  input logic                 rst_ni,
  input logic                 st_valid,
  input logic                 st_ready,
  input logic                 ckpt_take,
  input logic                 ckpt_commit,
  input logic                 ckpt_rollback,
  input logic                 spec_active,
  input logic                 busy,
  input logic                 overflow,
  input logic                 flush_req,
  input logic [LOG_DEPTH-1:0] log_valid
);

  p_take_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    (!spec_active && !busy && ckpt_take && !ckpt_commit && !ckpt_rollback) |=> spec_active);

  p_idle_empty_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (!spec_active && !busy) |-> (log_valid == '0));

  p_commit_clear_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (spec_active && ckpt_commit && !ckpt_rollback) |=> (log_valid == '0 && !spec_active));

  p_stall_replay_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    busy |-> !st_ready);

  p_drain_step_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && log_valid != '0) |=> ($countones(log_valid) == $past($countones(log_valid)) - 1));

  p_flush_once_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_req |=> !flush_req);

  p_flush_cause_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    flush_req |-> (busy && $past(spec_active && ckpt_rollback)));

  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (overflow && !ckpt_commit && !ckpt_rollback) |=> overflow);

  p_ovf_spec_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    overflow |-> spec_active);

  p_ovf_stall_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (spec_active && st_valid && !st_ready && !ckpt_rollback && !ckpt_commit) |=> overflow);

  p_rb_wins_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (spec_active && ckpt_rollback) |=> (busy && !spec_active));

endmodule

bind undo_log_queue ulq_checker #(
  .LOG_DEPTH (LOG_DEPTH)
) u_chk (
  .clk           (clk),
  .rst_ni        (rst_ni),
  .st_valid      (st_valid),
  .st_ready      (st_ready),
  .ckpt_take     (ckpt_take),
  .ckpt_commit   (ckpt_commit),
  .ckpt_rollback (ckpt_rollback),
  .spec_active   (spec_active),
  .busy          (busy),
  .overflow      (overflow),
  .flush_req     (flush_req),
  .log_valid     (log_valid)
);

// File: tb/undo_log_queue_test.sv
module undo_log_queue_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int DEP = 8;
  localparam int WORDS = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          st_valid;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic          st_ready;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;
  logic          ckpt_take, ckpt_commit, ckpt_rollback;
  logic          spec_active, busy, overflow, flush_req;

  undo_log_queue #(.ADDR_W(AW), .DATA_W(DW), .LOG_DEPTH(DEP)) uut (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .ckpt_take(ckpt_take), .ckpt_commit(ckpt_commit), .ckpt_rollback(ckpt_rollback),
    .spec_active(spec_active), .busy(busy), .overflow(overflow), .flush_req(flush_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  // behavioural reference
  logic [DW-1:0] m_mem [WORDS];
  logic [DW-1:0] m_log [int];
  bit            m_spec, m_busy, m_ovf, m_flush, m_known;
  int            m_bcnt;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input bit v, input int a, input int d, input bit tk, input bit cm,
                      input bit rb, input int ra);
    bit hit, full, rdy, acc;
    int n;
    @(negedge clk);
    st_valid = v; st_addr = a[AW-1:0]; st_data = d[DW-1:0];
    ckpt_take = tk; ckpt_commit = cm; ckpt_rollback = rb; rd_addr = ra[AW-1:0];
    #1;
    hit  = m_log.exists(a);
    n    = m_log.num();
    full = (n == DEP);
    rdy  = !m_busy && !(m_spec && (rb || (full && !hit)));
    check("R6 R8", "st_ready", st_ready, rdy);
    check("R6", "busy", busy, m_busy);
    check("R1", "spec_active", spec_active, m_spec);
    check("R8", "overflow", overflow, m_ovf);
    check("R7", "flush_req", flush_req, m_flush);
    if (m_known && !m_busy) check("R11 R2 R3 R5", "rd_data", rd_data, m_mem[ra]);
    acc = v && rdy;
    m_flush = 1'b0;
    if (m_busy) begin
      m_bcnt--;
      if (m_bcnt == 0) m_busy = 1'b0;
    end else if (m_spec) begin
      if (rb) begin
        foreach (m_log[k]) m_mem[k] = m_log[k];
        m_bcnt = (n == 0) ? 1 : n;
        m_log.delete();
        m_busy = 1'b1; m_spec = 1'b0; m_ovf = 1'b0; m_flush = 1'b1;
      end else if (cm) begin
        m_log.delete();
        m_spec = 1'b0; m_ovf = 1'b0;
      end else begin
        if (acc && !hit) m_log[a] = m_mem[a];
        if (v && full && !hit) m_ovf = 1'b1;
      end
    end else if (tk && !cm && !rb) begin
      m_spec = 1'b1;
    end
    if (acc) m_mem[a] = d[DW-1:0];
    @(posedge clk);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic store(input int a, input int d);
    tick(1, a, d, 0, 0, 0, a);
  endtask

  task automatic sweep();
    for (int i = 0; i < WORDS; i++) tick(0, 0, 0, 0, 0, 0, i);
  endtask

  task automatic drain();
    for (int i = 0; i < 20 && m_busy; i++) tick(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    m_spec = 0; m_busy = 0; m_ovf = 0; m_flush = 0; m_known = 0; m_bcnt = 0;
    rst_n = 1'b0;
    st_valid = 0; st_addr = '0; st_data = '0; rd_addr = '0;
    ckpt_take = 0; ckpt_commit = 0; ckpt_rollback = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: state after reset
    @(negedge clk);
    check("R10", "st_ready after reset", st_ready, 1);
    check("R10", "busy after reset", busy, 0);
    check("R10", "spec_active after reset", spec_active, 0);
    check("R10", "overflow after reset", overflow, 0);
    check("R10", "flush_req after reset", flush_req, 0);
    idle(2);

    // R4: fill memory with no checkpoint open, nothing logged
    for (int i = 0; i < WORDS; i++) store(i, (i * 37 + 5) & 16'hffff);
    m_known = 1'b1;
    sweep();

    // R1 R2 R3: speculative stores with repeats, then rollback (R6 R7)
    tick(0, 0, 0, 1, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0);          // R1: take while speculative ignored
    store(3, 16'haaaa);
    store(9, 16'hbbbb);
    store(3, 16'hcccc);                 // R3: same address, no new entry
    store(40, 16'hdddd);
    tick(0, 0, 0, 0, 0, 0, 3);          // R11: speculative data visible
    tick(1, 5, 16'h1234, 0, 0, 1, 0);   // R6: store in rollback cycle stalled
    tick(0, 0, 0, 1, 1, 1, 0);          // R9: commands ignored while busy
    drain();
    sweep();

    // R5: commit keeps speculative data; later rollback restores nothing
    tick(0, 0, 0, 1, 0, 0, 0);
    store(7, 16'h7777);
    store(8, 16'h8888);
    tick(1, 10, 16'h1010, 0, 1, 0, 10); // R5: store in commit cycle not logged
    tick(0, 0, 0, 0, 0, 1, 0);          // rollback when idle ignored
    tick(0, 0, 0, 1, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0);          // R6: empty log, busy one cycle
    drain();
    sweep();

    // R8: fill the log, refuse a new address, accept a logged one
    tick(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < DEP; i++) store(20 + i, 16'h5000 + i);
    store(50, 16'hee00);                // R8: refused, overflow rises
    store(50, 16'hee01);
    store(21, 16'hee02);                // R8: logged address accepted when full
    idle(2);                            // R8: overflow held
    tick(0, 0, 0, 0, 1, 0, 0);          // R5: commit clears overflow
    store(50, 16'hee03);
    sweep();

    // R9: commit and rollback together while speculative, rollback wins
    tick(0, 0, 0, 1, 0, 0, 0);
    store(30, 16'h3030);
    store(31, 16'h3131);
    tick(0, 0, 0, 1, 1, 1, 0);
    drain();
    // R9: take together with commit in idle does nothing
    tick(0, 0, 0, 1, 1, 0, 0);
    idle(1);
    // R8: overflow then rollback clears it and restores all entries
    tick(0, 0, 0, 1, 0, 0, 0);
    for (int i = 0; i < DEP + 2; i++) store(i * 5, 16'h6000 + i);
    tick(0, 0, 0, 0, 0, 1, 0);
    drain();
    sweep();

    // mixed traffic over a narrow address window
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom % 100;
      tick(($urandom % 2) == 1, $urandom % 12, $urandom, r < 8, (r >= 8 && r < 12),
           (r >= 12 && r < 16) || r == 99, $urandom % 12);
    end
    tick(0, 0, 0, 0, 0, 1, 0);
    drain();
    idle(2);
    sweep();

    summary();
    $finish;
  end

endmodule